// File: doc/BRIEF.md
# Multi-Channel Register-Programmed PWM Bank

The block drives a small bank of pulse-width-modulated pins. Each pin belongs to one channel. Software programs a channel through a byte-wide synchronous register port, which has an address, write data, a write strobe and combinational read data. For each channel it sets a 4-bit rate code and a 10-bit duty field. A shared enable register switches channels on and off one by one.

Each channel splits its input clock into quanta. One quantum lasts `PRE_BASE - code` clocks, which is 32 minus the code by default. A period is always `2**QUANTA_BITS` quanta long, which is 1024 by default. The output is high for the first `duty + 1` quanta of each period and low for the rest. A running channel therefore never produces 0 % duty. Only a clear enable bit holds the pin low. Duty and rate changes are held in shadow copies and take effect only at a period boundary. A channel that has just been enabled starts a fresh period at once.

Every channel has a two-state controller. In IDLE the counters are held at zero, the shadows follow the live registers and the pin is low. The transition START (enable seen) moves the controller to RUN. In RUN the prescaler and the quantum counter advance. At WRAP (the end of the last quantum) the shadows reload and the quantum counter returns to zero. The transition STOP (enable cleared) moves the controller back to IDLE.

Top module: `pwm_bank`

## Requirements
- R1: After reset every mapped register reads 0x00 and every pwm output is low.
- R2: Channel n has its duty low byte at address 0x60+2n and its odd register at 0x61+2n. The enable register is at 0x66, and bit n of it enables channel n. Every register reads back the last value written to it.
- R3: In an odd register, bits [7:4] hold the rate code and bits [1:0] hold duty bits [9:8]. Bits [3:2] read as zero. Enable register bits at or above NUM_CH read as zero.
- R4: A write to an unmapped address changes no register and no output. A read from an unmapped address returns 0x00.
- R5: One quantum lasts PRE_BASE minus the rate code clock cycles, which is 32−F by default.
- R6: A period lasts 2**QUANTA_BITS quanta whatever the rate code.
- R7: The output is high for the first duty+1 quanta of each period and low for the rest. The duty value used is the low QUANTA_BITS bits of the 10-bit field. The all-ones value keeps the output high through the whole period.
- R8: When a channel's enable bit is cleared, its output is low in the first cycle after the write. Its counters return to zero, so re-enabling it gives a whole fresh period.
- R9: A duty or rate write to a running channel leaves the current period unchanged and applies from the next period on.
- R10: A newly enabled channel enters RUN on the clock edge after the enable write. Its output is high from then on, with its first period starting there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the bank with a 16-quantum period so that whole periods can be timed. It sweeps all sixteen rate codes and all sixteen duty values, timing the high time and the rise-to-rise spacing in clocks. A prescaler off by one, or one dividing by the code instead of 32 minus the code, would shift every one of those counts. So would a duty compare that forgets the +1 offset. Mid-period writes of duty and rate test the shadow registers: a design without them would truncate the running period. Disable during a high phase and re-enable test both the immediate low and the counter clear, where a design that kept stale counters would give a short first period. Writes to addresses next to the map test address decoding, where aliasing would turn on channels or corrupt registers.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int DUTY_W = 10;
    localparam int CODE_W = 4;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_BASE = 32,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CW = $clog2(PRE_BASE);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = CW'(PRE_BASE - 1 - int'(code));
    assign tick = run && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int QUANTA_BITS = 10,
    parameter int PRE_BASE    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty_live,
    input  logic [CODE_W-1:0] code_live,
    output logic              pwm_o
);
    localparam logic [QUANTA_BITS-1:0] Q_LAST = '1;

    ch_state_e state_q, state_d;
    logic [QUANTA_BITS-1:0] q_cnt;
    logic [DUTY_W-1:0]      duty_sh;
    logic [CODE_W-1:0]      code_sh;
    logic                   running;
    logic                   tick;
    logic                   wrap;

    assign running = (state_q == CH_RUN) && en;
    assign wrap    = running && tick && (q_cnt == Q_LAST);

    pwm_prescaler #(
        .PRE_BASE (PRE_BASE),
        .CODE_W   (CODE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .code  (code_sh),
        .tick  (tick)
    );

    // next state: START (IDLE->RUN), STOP (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (en)  state_d = CH_RUN;
            CH_RUN:  if (!en) state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // quantum counter and shadow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cnt   <= '0;
            duty_sh <= '0;
            code_sh <= '0;
        end else if (!running) begin
            q_cnt   <= '0;
            duty_sh <= duty_live;
            code_sh <= code_live;
        end else begin
            if (tick) q_cnt <= q_cnt + 1'b1;
            if (wrap) begin
                duty_sh <= duty_live;
                code_sh <= code_live;
            end
        end
    end

    // output process
    always_comb begin
        pwm_o = 1'b0;
        unique case (state_q)
            CH_IDLE: pwm_o = 1'b0;
            CH_RUN:  pwm_o = en && (q_cnt <= duty_sh[QUANTA_BITS-1:0]);
        endcase
    end

    // R8
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q_cnt == '0));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(duty_sh) && $stable(code_sh)));

    // R7
    period_starts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (pwm_o || !en));

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int         NUM_CH    = 3,
    parameter logic [7:0] BASE_ADDR = 8'h60,
    parameter logic [7:0] EN_ADDR   = 8'h66
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [7:0]                     addr,
    input  logic [7:0]                     wdata,
    input  logic                           we,
    output logic [7:0]                     rdata,
    output logic [NUM_CH-1:0][DUTY_W-1:0]  duty_o,
    output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
    output logic [NUM_CH-1:0]              en_o
);
    logic [NUM_CH-1:0][7:0]        lo_q;
    logic [NUM_CH-1:0][1:0]        hi_q;
    logic [NUM_CH-1:0][CODE_W-1:0] code_q;
    logic [NUM_CH-1:0]             en_q;
    logic                          mapped;

    assign mapped = (addr == EN_ADDR) ||
                    ((addr >= BASE_ADDR) && (addr < BASE_ADDR + 8'(2 * NUM_CH)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [7:0] A_LO = BASE_ADDR + 8'(2 * i);
        localparam logic [7:0] A_HI = A_LO + 8'd1;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[i]   <= '0;
                hi_q[i]   <= '0;
                code_q[i] <= '0;
            end else if (we) begin
                if (addr == A_LO) lo_q[i] <= wdata;
                if (addr == A_HI) begin
                    hi_q[i]   <= wdata[1:0];
                    code_q[i] <= wdata[7:4];
                end
            end
        end

        assign duty_o[i] = {hi_q[i], lo_q[i]};
        assign code_o[i] = code_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      en_q <= '0;
        else if (we && addr == EN_ADDR)  en_q <= wdata[NUM_CH-1:0];
    end

    assign en_o = en_q;

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == BASE_ADDR + 8'(2 * i))
                rdata = lo_q[i];
            if (addr == BASE_ADDR + 8'(2 * i + 1))
                rdata = {code_q[i], 2'b00, hi_q[i]};
        end
        if (addr == EN_ADDR) rdata = 8'(en_q);
    end

    // R4
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == 8'h00));

    // R3
    en_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == EN_ADDR) |-> ((rdata >> NUM_CH) == 8'h00));

    // R3
    odd_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mapped && addr != EN_ADDR && addr[0] != BASE_ADDR[0]) |-> (rdata[3:2] == 2'b00));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int         NUM_CH      = 3,
    parameter int         QUANTA_BITS = 10,
    parameter int         PRE_BASE    = 32,
    parameter logic [7:0] BASE_ADDR   = 8'h60,
    parameter logic [7:0] EN_ADDR     = 8'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][DUTY_W-1:0] duty;
    logic [NUM_CH-1:0][CODE_W-1:0] code;
    logic [NUM_CH-1:0]             en;

    pwm_regfile #(
        .NUM_CH    (NUM_CH),
        .BASE_ADDR (BASE_ADDR),
        .EN_ADDR   (EN_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .we     (reg_we),
        .rdata  (reg_rdata),
        .duty_o (duty),
        .code_o (code),
        .en_o   (en)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pwm
        pwm_channel #(
            .QUANTA_BITS (QUANTA_BITS),
            .PRE_BASE    (PRE_BASE)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en[i]),
            .duty_live (duty[i]),
            .code_live (code[i]),
            .pwm_o     (pwm_out[i])
        );
    end

endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
    localparam int NCH = 3;
    localparam int QB  = 4;
    localparam int NQ  = 1 << QB;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [7:0]     reg_wdata = '0;
    logic           reg_we = 1'b0;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH), .QUANTA_BITS(QB)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic prog(input int ch, input int duty, input int f);
        wr(8'(8'h60 + 2 * ch), 8'(duty & 8'hFF));
        wr(8'(8'h61 + 2 * ch), 8'(((f & 15) << 4) | ((duty >> 8) & 3)));
    endtask

    task automatic measure(input int ch, input int limit, output int hi, output int per);
        bit prev;
        int guard = 0;
        while (!pwm_out[ch] && guard < 4000) begin @(negedge clk); guard++; end
        hi = 0; per = 0;
        for (int i = 0; i < limit; i++) begin
            if (pwm_out[ch]) hi++;
            per++;
            prev = pwm_out[ch];
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v, hi, per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 8'h60; a <= 8'h66; a++) begin
            rd(8'(a), v);
            chk("R1 reset reg", v, 0);
        end
        chk("R1 outputs low", int'(pwm_out), 0);

        // R2 / R3: readback through the map
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) begin
            wr(8'(8'h60 + 2 * ch), 8'(8'hA5 + ch));
            wr(8'(8'h61 + 2 * ch), 8'hFF);
        end
        wr(8'h66, 8'hFD);
        for (int ch = 0; ch < NCH; ch++) begin
            rd(8'(8'h60 + 2 * ch), v); chk("R2 duty low byte", v, 8'hA5 + ch);
            rd(8'(8'h61 + 2 * ch), v); chk("R3 odd reg mask", v, 8'hF3);
        end
        rd(8'h66, v); chk("R3 enable upper bits", v, 8'h05);
        @(negedge clk);
        wr(8'h66, 8'h00);
        rd(8'h66, v); chk("R2 enable readback", v, 0);
        @(negedge clk);

        // R4: unmapped addresses
        wr(8'h67, 8'hFF); wr(8'h5F, 8'hFF); wr(8'h70, 8'hFF); wr(8'h00, 8'hFF);
        rd(8'h67, v); chk("R4 read 0x67", v, 0);
        rd(8'h5F, v); chk("R4 read 0x5F", v, 0);
        rd(8'h00, v); chk("R4 read 0x00", v, 0);
        rd(8'h66, v); chk("R4 enable untouched", v, 0);
        rd(8'h60, v); chk("R4 ch0 low untouched", v, 8'hA5);
        rd(8'h65, v); chk("R4 ch2 odd untouched", v, 8'hF3);
        repeat (5) @(negedge clk);
        chk("R4 outputs still low", int'(pwm_out), 0);

        // R10: fresh start timing
        prog(1, 0, 15);
        wr(8'h66, 8'h02);
        chk("R10 low right after write edge", int'(pwm_out[1]), 0);
        @(negedge clk);
        chk("R10 high one edge later", int'(pwm_out[1]), 1);
        wr(8'h66, 8'h00);

        // R5 / R6 / R7: rate code sweep on channel 0
        for (int f = 0; f < 16; f++) begin
            wr(8'h66, 8'h00);
            prog(0, 2, f);
            wr(8'h66, 8'h01);
            measure(0, 4096, hi, per);
            chk($sformatf("R5 R6 period f=%0d", f), per, NQ * (32 - f));
            chk($sformatf("R7 high f=%0d", f), hi, 3 * (32 - f));
        end

        // R7: duty sweep on channel 1
        for (int d = 0; d < NQ; d++) begin
            wr(8'h66, 8'h00);
            prog(1, d, 15);
            wr(8'h66, 8'h02);
            measure(1, NQ * 17, hi, per);
            chk($sformatf("R7 high d=%0d", d), hi, (d + 1) * 17);
            chk($sformatf("R6 period d=%0d", d), per, NQ * 17);
        end

        // R2: channel 2 mapping
        wr(8'h66, 8'h00);
        prog(2, 5, 8);
        wr(8'h66, 8'h04);
        measure(2, 4096, hi, per);
        chk("R2 ch2 high", hi, 6 * 24);
        chk("R2 ch2 period", per, NQ * 24);
        chk("R2 others idle", int'(pwm_out[1:0]), 0);

        // R9: mid-period update waits for boundary
        wr(8'h66, 8'h00);
        prog(0, 3, 15);
        wr(8'h66, 8'h01);
        @(negedge clk);
        hi = 0;
        for (int i = 0; i < NQ * 17; i++) begin
            if (pwm_out[0]) hi++;
            if (i == 5) begin reg_addr = 8'h60; reg_wdata = 8'd10; reg_we = 1'b1; end
            if (i == 6) begin reg_addr = 8'h61; reg_wdata = 8'h00; reg_we = 1'b1; end
            if (i == 7) reg_we = 1'b0;
            @(negedge clk);
        end
        chk("R9 current period kept", hi, 4 * 17);
        measure(0, 4096, hi, per);
        chk("R9 next period high", hi, 11 * 32);
        chk("R9 next period length", per, NQ * 32);

        // R8: disable during high phase, then restart
        wr(8'h66, 8'h00);
        prog(2, 7, 15);
        wr(8'h66, 8'h04);
        repeat (4) @(negedge clk);
        wr(8'h66, 8'h00);
        chk("R8 low after disable", int'(pwm_out[2]), 0);
        repeat (40) @(negedge clk);
        chk("R8 stays low", int'(pwm_out[2]), 0);
        wr(8'h66, 8'h04);
        measure(2, 4096, hi, per);
        chk("R8 fresh period high", hi, 8 * 17);
        chk("R8 fresh period length", per, NQ * 17);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule